// File: doc/BRIEF.md
# PCIe Receive Payload Realigner

This block sits behind a 64-bit streaming receive port that delivers PCI Express transaction layer packets two dwords per beat. The earlier dword is in bits [31:0] and the later one in bits [63:32]. The block strips the three- or four-dword header. It then re-packs the payload so that payload dword 0 always lands in the low half of the first output beat, and payload dwords follow in order, two per beat, with byte enables that follow their dwords.

On the input side, where the first payload dword sits depends on address bit 2 and on the header size, so a half beat may carry no data. The upstream sender may also keep presenting beats for up to three cycles after the block lowers its ready. A small buffer absorbs those beats, and ready is withdrawn early enough that none is lost. Packets that carry no payload produce no output beats. A one-cycle flag marks each of them instead.

Top module: `tlp_payload_realigner`

## Requirements
- R1: Header dwords never reach the output. Payload dwords leave in order: dword 2j in out_data_o[31:0] and dword 2j+1 in out_data_o[63:32] of output beat j.
- R2: Header dword 0 is decoded as follows. Bit 29 set means a 4-dword header and bit 30 set means a payload is present. Bits [9:0] give the payload length in dwords. Address bit 2 is bit 2 of header dword 2 for a 3-dword header, or of header dword 3 for a 4-dword header. With a 4-dword header and address bit 2 set, payload dword 0 is taken from bits [63:32] of the beat after the header, and bits [31:0] of that beat are ignored.
- R3: With a 3-dword header and address bit 2 set, payload dword 0 is taken from bits [63:32] of the second header beat.
- R4: With address bit 2 clear, for either header size, payload dword 0 is taken from bits [31:0] of the first beat after the header beats, and the upper half of the second beat of a 3-dword header is ignored.
- R5: in_be_i[3:0] qualifies in_data_i[31:0] and in_be_i[7:4] qualifies in_data_i[63:32], and each output byte enable follows its dword, partial first and last enables included. An odd payload length ends on a beat whose out_be_o[7:4] and out_data_o[63:32] are zero.
- R6: out_sop_o is set on the first output beat of a packet and out_eop_o on the beat holding the last payload dword. A length field of 0 means 1024 dwords.
- R7: A packet with bit 30 of header dword 0 clear gives no output beat, and hdr_only_o pulses for exactly one cycle per such packet.
- R8: in_ready_o is high only while at least LATE_BEATS+1 buffer entries are free. Every beat presented with in_valid_i up to LATE_BEATS cycles after in_ready_o falls is kept.
- R9: While out_valid_o is high and out_ready_i low, out_valid_o stays high and the output data, enables and framing hold their values.
- R10: After reset, in_ready_o is high and out_valid_o and hdr_only_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat present (accepted whenever high) |
| in_sop_i | input | 1 | First beat of a packet |
| in_eop_i | input | 1 | Last beat of a packet |
| in_data_i | input | 64 | Two dwords, earlier one low |
| in_be_i | input | 8 | Byte enables, bit n qualifies byte n |
| in_ready_o | output | 1 | Sender may start new beats |
| out_valid_o | output | 1 | Output payload beat valid |
| out_ready_i | input | 1 | Downstream takes the beat |
| out_data_o | output | 64 | Packed payload dwords |
| out_be_o | output | 8 | Byte enables of the packed dwords |
| out_sop_o | output | 1 | First payload beat |
| out_eop_o | output | 1 | Last payload beat |
| hdr_only_o | output | 1 | One-cycle flag for a packet without payload |

## Verification
A stale remaining-dword counter or a wrong shift decision shows up on the very next output beat. It appears as a dword that is swapped or duplicated, or as an end-of-packet marker that arrives one beat early or late, and the next packet's start marker then lands mid-stream. A buffer count that drifts either loses a late beat or holds ready low forever. The first case becomes a missing payload dword a few beats later. The second case stalls the stream until the run ends.

// File: rtl/tlp_rlgn_pkg.sv
package tlp_rlgn_pkg;
  localparam int BUS_W = 64;
  localparam int BE_W  = BUS_W / 8;
  localparam int REM_W = 11;
  localparam int HDR4_BIT = 29;
  localparam int HASD_BIT = 30;
  localparam int ADDR2_LO = 2;
  localparam int ADDR2_HI = 34;

  typedef struct packed {
    logic             sop;
    logic             eop;
    logic [BE_W-1:0]  be;
    logic [BUS_W-1:0] data;
  } beat_t;

  typedef enum logic [1:0] {ST_H1, ST_H2, ST_DAT, ST_FLUSH} st_e;
endpackage

// File: rtl/tlp_rlgn_fifo.sv
module tlp_rlgn_fifo
  import tlp_rlgn_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SLACK = 3,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  beat_t         din_i,
  input  logic          pop_i,
  output beat_t         head_o,
  output logic          empty_o,
  output logic          ready_o,
  output logic [CW-1:0] cnt_o
);
  beat_t         mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign push_ok = push_i && (cnt_q != CW'(DEPTH));
  assign pop_ok  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  // keep room for SLACK late beats plus one
  assign ready_o = (CW'(DEPTH) - cnt_q) > CW'(SLACK);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/tlp_rlgn_core.sv
module tlp_rlgn_core
  import tlp_rlgn_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  beat_t            head_i,
  input  logic             hv_i,
  output logic             pop_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [BUS_W-1:0] out_data_o,
  output logic [BE_W-1:0]  out_be_o,
  output logic             out_sop_o,
  output logic             out_eop_o,
  output logic             hdr_only_o
);
  st_e              st_q, st_d;
  logic             hdr4_q, hdr4_d, hasd_q, hasd_d, shift_q, shift_d;
  logic             pend_vld_q, pend_vld_d, sop_pend_q, sop_pend_d;
  logic [31:0]      pend_q, pend_d;
  logic [3:0]       pend_be_q, pend_be_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic [31:0]      lo, hi;
  logic             addr2;
  logic             unused_eop;

  assign lo         = head_i.data[31:0];
  assign hi         = head_i.data[63:32];
  assign addr2      = hdr4_q ? head_i.data[ADDR2_HI] : head_i.data[ADDR2_LO];
  assign unused_eop = head_i.eop;

  always_comb begin
    st_d = st_q; hdr4_d = hdr4_q; hasd_d = hasd_q; shift_d = shift_q;
    pend_vld_d = pend_vld_q; sop_pend_d = sop_pend_q;
    pend_d = pend_q; pend_be_d = pend_be_q; rem_d = rem_q;
    pop_o = 1'b0; out_valid_o = 1'b0; out_data_o = '0; out_be_o = '0;
    out_sop_o = 1'b0; out_eop_o = 1'b0; hdr_only_o = 1'b0;
    unique case (st_q)
      ST_H1: if (hv_i) begin
        pop_o = 1'b1;
        if (head_i.sop) begin
          hdr4_d = head_i.data[HDR4_BIT];
          hasd_d = head_i.data[HASD_BIT];
          rem_d  = {head_i.data[9:0] == 10'd0, head_i.data[9:0]};
          st_d   = ST_H2;
        end
      end
      ST_H2: if (hv_i) begin
        pend_vld_d = 1'b0;
        sop_pend_d = 1'b1;
        if (!hasd_q) begin
          pop_o = 1'b1; hdr_only_o = 1'b1; st_d = ST_H1;
        end else if (!hdr4_q && addr2) begin
          // data0 shares this beat with header dword 2: keep it at the head
          shift_d = 1'b1; st_d = ST_DAT;
        end else begin
          pop_o = 1'b1; shift_d = hdr4_q && addr2; st_d = ST_DAT;
        end
      end
      ST_DAT: if (hv_i) begin
        if (!shift_q) begin
          out_valid_o = 1'b1;
          out_data_o  = {(rem_q == 11'd1) ? 32'd0 : hi, lo};
          out_be_o    = {(rem_q == 11'd1) ? 4'd0 : head_i.be[7:4], head_i.be[3:0]};
          out_sop_o   = sop_pend_q;
          out_eop_o   = rem_q <= 11'd2;
          if (out_ready_i) begin
            pop_o = 1'b1; sop_pend_d = 1'b0;
            rem_d = rem_q - ((rem_q == 11'd1) ? 11'd1 : 11'd2);
            if (rem_q <= 11'd2) st_d = ST_H1;
          end
        end else if (!pend_vld_q) begin
          if (rem_q == 11'd1) begin
            out_valid_o = 1'b1;
            out_data_o  = {32'd0, hi};
            out_be_o    = {4'd0, head_i.be[7:4]};
            out_sop_o   = sop_pend_q;
            out_eop_o   = 1'b1;
            if (out_ready_i) begin pop_o = 1'b1; st_d = ST_H1; end
          end else begin
            pop_o = 1'b1; pend_d = hi; pend_be_d = head_i.be[7:4];
            pend_vld_d = 1'b1; rem_d = rem_q - 11'd1;
          end
        end else begin
          out_valid_o = 1'b1;
          out_data_o  = {lo, pend_q};
          out_be_o    = {head_i.be[3:0], pend_be_q};
          out_sop_o   = sop_pend_q;
          out_eop_o   = rem_q == 11'd1;
          if (out_ready_i) begin
            pop_o = 1'b1; sop_pend_d = 1'b0;
            if (rem_q == 11'd1) begin
              st_d = ST_H1; pend_vld_d = 1'b0;
            end else begin
              pend_d = hi; pend_be_d = head_i.be[7:4]; rem_d = rem_q - 11'd2;
              if (rem_q == 11'd2) st_d = ST_FLUSH;
            end
          end
        end
      end
      ST_FLUSH: begin
        out_valid_o = 1'b1;
        out_data_o  = {32'd0, pend_q};
        out_be_o    = {4'd0, pend_be_q};
        out_sop_o   = sop_pend_q;
        out_eop_o   = 1'b1;
        if (out_ready_i) begin st_d = ST_H1; pend_vld_d = 1'b0; end
      end
      default: st_d = ST_H1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_H1; hdr4_q <= 1'b0; hasd_q <= 1'b0; shift_q <= 1'b0;
      pend_vld_q <= 1'b0; sop_pend_q <= 1'b0; pend_q <= '0;
      pend_be_q <= '0; rem_q <= '0;
    end else begin
      st_q <= st_d; hdr4_q <= hdr4_d; hasd_q <= hasd_d; shift_q <= shift_d;
      pend_vld_q <= pend_vld_d; sop_pend_q <= sop_pend_d; pend_q <= pend_d;
      pend_be_q <= pend_be_d; rem_q <= rem_d;
    end
  end
endmodule

// File: rtl/tlp_payload_realigner.sv
module tlp_payload_realigner
  import tlp_rlgn_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LATE_BEATS = 3,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic        in_sop_i,
  input  logic        in_eop_i,
  input  logic [63:0] in_data_i,
  input  logic [7:0]  in_be_i,
  output logic        in_ready_o,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [63:0] out_data_o,
  output logic [7:0]  out_be_o,
  output logic        out_sop_o,
  output logic        out_eop_o,
  output logic        hdr_only_o
);
  beat_t            in_beat, head;
  logic             empty, pop;
  logic [CNT_W-1:0] fifo_cnt;

  assign in_beat = '{sop: in_sop_i, eop: in_eop_i, be: in_be_i, data: in_data_i};

  tlp_rlgn_fifo #(.DEPTH(FIFO_DEPTH), .SLACK(LATE_BEATS)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (in_valid_i),
    .din_i  (in_beat),
    .pop_i  (pop),
    .head_o (head),
    .empty_o(empty),
    .ready_o(in_ready_o),
    .cnt_o  (fifo_cnt)
  );

  tlp_rlgn_core u_core (
    .clk_i, .rst_ni,
    .head_i     (head),
    .hv_i       (!empty),
    .pop_o      (pop),
    .out_valid_o,
    .out_ready_i,
    .out_data_o,
    .out_be_o,
    .out_sop_o,
    .out_eop_o,
    .hdr_only_o
  );
endmodule

// File: rtl/tlp_rlgn_chk.sv
module tlp_rlgn_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic [CW-1:0] fifo_cnt,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [63:0]   out_data_o,
  input logic [7:0]    out_be_o,
  input logic          out_sop_o,
  input logic          out_eop_o,
  input logic          hdr_only_o
);
  logic in_pkt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_pkt_q <= 1'b0;
    else if (out_valid_o && out_ready_i) in_pkt_q <= !out_eop_o;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> fifo_cnt < CW'(DEPTH));

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) &&
    $stable(out_be_o) && $stable(out_sop_o) && $stable(out_eop_o));

  // R6
  sop_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_sop_o |-> !in_pkt_q);

  // R6
  cont_in_pkt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !out_sop_o |-> in_pkt_q);

  // R5
  mid_upper_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_eop_o |-> out_be_o[7:4] == 4'hF);

  // R7
  hdr_only_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_only_o |-> !out_valid_o);
endmodule

bind tlp_payload_realigner tlp_rlgn_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .fifo_cnt(fifo_cnt),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
  .out_be_o(out_be_o), .out_sop_o(out_sop_o), .out_eop_o(out_eop_o),
  .hdr_only_o(hdr_only_o)
);

// File: tb/sim_tlp_payload_realigner.sv
module sim_tlp_payload_realigner;
  import tlp_rlgn_pkg::*;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0, in_sop_i = 1'b0, in_eop_i = 1'b0;
  logic [63:0] in_data_i = '0;
  logic [7:0]  in_be_i = '0;
  logic in_ready_o, out_valid_o, out_ready_i = 1'b0;
  logic [63:0] out_data_o;
  logic [7:0]  out_be_o;
  logic out_sop_o, out_eop_o, hdr_only_o;

  always #2 clk = ~clk;

  tlp_payload_realigner u0 (
    .clk_i(clk), .rst_ni, .in_valid_i, .in_sop_i, .in_eop_i, .in_data_i,
    .in_be_i, .in_ready_o, .out_valid_o, .out_ready_i, .out_data_o,
    .out_be_o, .out_sop_o, .out_eop_o, .hdr_only_o
  );

  beat_t src_q[$];
  beat_t exp_q[$];
  string tag_q[$];
  int errors = 0, checks = 0, hdr_exp = 0, hdr_seen = 0, pkt_id = 0;
  int sink_mode = 0;
  bit src_gap = 0, ready_low_seen = 0, prev_stall = 0, done = 0;
  logic [3:0] rdy_hist = '0;
  logic [63:0] prev_data;
  logic [7:0]  prev_be;
  logic prev_sop, prev_eop;

  task automatic chk(input bit ok, input string tag, input logic [63:0] got,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic send_pkt(input bit hdr4, input bit hasd, input int len,
                          input bit a2, input logic [3:0] fbe,
                          input logic [3:0] lbe, input string tag);
    logic [31:0] sd[$];
    logic [3:0]  sb[$];
    logic [31:0] pd[$];
    logic [3:0]  pb[$];
    int hn, s0, nb;
    pkt_id++;
    hn = hdr4 ? 4 : 3;
    sd.push_back((32'(hasd) << 30) | (32'(hdr4) << 29) | 32'(len % 1024));
    sd.push_back(32'h0000_00FF | (32'(pkt_id) << 8));
    if (hdr4) begin
      sd.push_back(32'h0000_0001);
      sd.push_back(32'h2000_0000 | (32'(a2) << 2));
    end else sd.push_back(32'h1000_0000 | (32'(a2) << 2));
    for (int i = 0; i < hn; i++) sb.push_back(4'hF);
    if (!hasd) hdr_exp++;
    else begin
      s0 = hn + (((hn % 2) != int'(a2)) ? 1 : 0);
      while (sd.size() < s0) begin
        sd.push_back(32'hDEAD_0000 | 32'(pkt_id)); sb.push_back(4'hF);
      end
      for (int k = 0; k < len; k++) begin
        pd.push_back(32'hA000_0000 | (32'(pkt_id) << 16) | 32'(k));
        pb.push_back(k == 0 ? fbe : (k == len - 1 ? lbe : 4'hF));
        sd.push_back(pd[k]); sb.push_back(pb[k]);
      end
    end
    if (sd.size() % 2) begin sd.push_back(32'hBAD0_BAD0); sb.push_back(4'h0); end
    nb = sd.size() / 2;
    for (int i = 0; i < nb; i++)
      src_q.push_back('{sop: i == 0, eop: i == nb - 1,
                        be: {sb[2*i+1], sb[2*i]}, data: {sd[2*i+1], sd[2*i]}});
    for (int j = 0; 2 * j < len && hasd; j++) begin
      beat_t e;
      e.sop  = (j == 0);
      e.eop  = (2 * j + 2 >= len);
      e.data = {(2*j+1 < len) ? pd[2*j+1] : 32'd0, pd[2*j]};
      e.be   = {(2*j+1 < len) ? pb[2*j+1] : 4'd0, pb[2*j]};
      exp_q.push_back(e); tag_q.push_back(tag);
    end
  endtask

  // source, sink and monitor share one negedge process
  always @(negedge clk) begin
    rdy_hist = {rdy_hist[2:0], in_ready_o};
    if (src_q.size() > 0 && rdy_hist[3] && (!src_gap || ($urandom % 4) != 0)) begin
      beat_t b;
      b = src_q.pop_front();
      in_valid_i = 1'b1; in_sop_i = b.sop; in_eop_i = b.eop;
      in_data_i = b.data; in_be_i = b.be;
    end else begin
      in_valid_i = 1'b0; in_data_i = '0; in_be_i = '0; in_sop_i = 1'b0; in_eop_i = 1'b0;
    end
    case (sink_mode)
      0: out_ready_i = 1'b1;
      1: out_ready_i = ($urandom % 3) != 0;
      default: out_ready_i = 1'b0;
    endcase
    #1;
    if (rst_ni) begin
      if (!in_ready_o) ready_low_seen = 1;
      if (prev_stall)
        chk(out_valid_o && out_data_o == prev_data && out_be_o == prev_be &&
            out_sop_o == prev_sop && out_eop_o == prev_eop,
            "R9 hold under stall", out_data_o, prev_data);
      prev_stall = out_valid_o && !out_ready_i;
      prev_data = out_data_o; prev_be = out_be_o;
      prev_sop = out_sop_o; prev_eop = out_eop_o;
      if (hdr_only_o) hdr_seen++;
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) chk(0, "R1 unexpected beat", out_data_o, 64'd0);
        else begin
          beat_t e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk(out_data_o == e.data, {t, " data"}, out_data_o, e.data);
          chk(out_be_o == e.be, {t, " be"}, 64'(out_be_o), 64'(e.be));
          chk(out_sop_o == e.sop && out_eop_o == e.eop, {t, " R6 framing"},
              {62'd0, out_sop_o, out_eop_o}, {62'd0, e.sop, e.eop});
        end
      end
    end
  end

  task automatic drain();
    while (src_q.size() != 0 || exp_q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    chk(in_ready_o == 1'b1, "R10 ready after reset", 64'(in_ready_o), 64'd1);
    chk(out_valid_o == 1'b0, "R10 valid after reset", 64'(out_valid_o), 64'd0);
    chk(hdr_only_o == 1'b0, "R10 flag after reset", 64'(hdr_only_o), 64'd0);

    sink_mode = 0; src_gap = 0;
    send_pkt(1, 1, 3, 1, 4'h8, 4'hF, "R2 4dw odd addr");
    send_pkt(1, 1, 1, 1, 4'h8, 4'h8, "R2 4dw odd addr len1");
    send_pkt(1, 1, 2, 1, 4'hC, 4'h3, "R2 R5 4dw odd addr len2");
    send_pkt(3'd0 == 0, 1, 4, 0, 4'hF, 4'h1, "R4 4dw even addr");
    send_pkt(0, 1, 1, 1, 4'h2, 4'h2, "R3 3dw odd addr len1");
    send_pkt(0, 1, 2, 1, 4'hF, 4'h7, "R3 3dw odd addr len2");
    send_pkt(0, 1, 5, 1, 4'hE, 4'h1, "R3 R5 3dw odd addr len5");
    send_pkt(0, 1, 3, 0, 4'hF, 4'hF, "R4 R5 3dw even addr len3");
    send_pkt(0, 0, 1, 0, 4'hF, 4'hF, "R7 3dw no payload");
    send_pkt(1, 1, 5, 0, 4'h1, 4'hF, "R1 R5 4dw even len5");
    send_pkt(1, 0, 1, 1, 4'hF, 4'hF, "R7 4dw no payload");
    drain();

    sink_mode = 1; src_gap = 1;
    send_pkt(0, 1, 1024, 0, 4'hF, 4'hF, "R6 len field zero");
    send_pkt(1, 1, 7, 1, 4'h8, 4'h3, "R1 R2 random flow");
    send_pkt(0, 0, 1, 1, 4'hF, 4'hF, "R7 no payload random");
    send_pkt(0, 1, 6, 1, 4'hF, 4'hF, "R3 random flow");
    drain();

    sink_mode = 2; src_gap = 0;
    send_pkt(1, 1, 6, 1, 4'hF, 4'hF, "R8 stall pkt a");
    send_pkt(1, 1, 6, 1, 4'hF, 4'hF, "R8 stall pkt b");
    send_pkt(0, 1, 6, 0, 4'hF, 4'hF, "R8 stall pkt c");
    repeat (40) @(negedge clk);
    #1;
    chk(in_ready_o == 1'b0, "R8 ready low when buffer near full", 64'(in_ready_o), 64'd0);
    sink_mode = 0;
    drain();

    chk(ready_low_seen, "R8 ready dropped", 64'(ready_low_seen), 64'd1);
    chk(exp_q.size() == 0, "R1 all payload delivered", 64'(exp_q.size()), 64'd0);
    chk(hdr_seen == hdr_exp, "R7 header-only flags", 64'(hdr_seen), 64'(hdr_exp));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule